// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block steps one gated power island through its power-up and power-down sequences. It drives a five-bit control word for the island: a two-stage power-switch enable, the isolation clamp, an active-low reset and a clock disable. It also drives the SRAM power-down bits and a bus-protection request. Between steps it waits for acknowledgements from the switch status readbacks, the SRAM and the bus fabric. Every wait is polled on a slow tick and abandons the sequence after a timeout.

Software starts a sequence with a one-cycle request strobe and a direction bit. It watches a busy flag, two readback flags (fully on, fully off) and a sticky error flag that is cleared by writing one. Parameters select the SRAM power-down and acknowledge masks. A parameter picks whether the SRAM acknowledge is polled on power-up or a fixed delay is used. Another parameter picks whether a bus-protection handshake exists.

Top module: `pd_seq_top`

## Requirements
- R1: Out of reset the control word reads 5'b10010 (switches off, isolation on, reset held, clock disabled). The SRAM power-down output equals the power-down mask, bus protection is requested when present, the off flag is 1, and the on, busy and error flags are 0.
- R2: Control bit layout: bit 0 is the active-low island reset, bit 1 isolation enable, bit 2 primary switch enable, bit 3 secondary switch enable, bit 4 clock disable. A fully powered island shows 5'b01101.
- R3: Power-up raises the primary switch enable, then raises the secondary switch enable on a later cycle.
- R4: After both switches are enabled, power-up proceeds only when both status inputs read 1. If one reads 1 and the other reads 0, the island is still in transition and the wait continues until it times out.
- R5: Once power is confirmed, power-up clears the clock disable, then clears isolation, then releases reset, then clears the SRAM power-down bits, each on its own cycle.
- R6: In polled mode, power-up waits until every acknowledge bit selected by the acknowledge mask reads 0; unselected bits are ignored. In fixed-wait mode it waits for FIXED_WAIT_TICKS poll intervals and ignores the acknowledge input.
- R7: When bus protection is present, its request is dropped as the last step of power-up, after which the acknowledge must read 0. It is raised as the first step of power-down, after which the acknowledge must read 1.
- R8: Power-down sets the SRAM power-down bits and waits until every selected acknowledge bit reads 1. It then sets isolation, asserts reset, sets the clock disable, drops the primary switch and drops the secondary switch, in that order.
- R9: Power-down finishes, and the off flag rises, only after both status inputs have read 0.
- R10: Wait conditions are sampled once per poll interval of TICK_CYC cycles. A wait that is not met within TIMEOUT_TICKS intervals returns the sequencer to idle and sets the sticky error flag. No output changes on that cycle, and on and off both read 0 until a later sequence completes. Writing 1 to the clear input clears the error flag.
- R11: A request that arrives while busy is ignored: the running sequence completes unchanged and no second sequence follows.
- R12: A power-on request while the on flag is 1, or a power-off request while the off flag is 1, leaves busy low and changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | One-cycle request strobe |
| req_on_i | input | 1 | Request direction: 1 power on, 0 power off |
| err_clr_i | input | 1 | Write-one-to-clear for the error flag |
| pwr_sta_i | input | 1 | Primary switch status readback |
| pwr_sta2_i | input | 1 | Secondary switch status readback |
| sram_ack_i | input | SRAM_W | SRAM power-down acknowledge bits |
| bus_ack_i | input | 1 | Bus-protection acknowledge |
| ctrl_o | output | 5 | Island control word (layout in R2) |
| sram_pdn_o | output | SRAM_W | SRAM power-down controls |
| bus_prot_o | output | 1 | Bus-protection request |
| busy_o | output | 1 | Sequence in progress |
| dom_on_o | output | 1 | Island fully on |
| dom_off_o | output | 1 | Island fully off |
| err_o | output | 1 | Sticky timeout error |

## Verification
The bound checker watches the step orderings on every cycle: the secondary switch never rises ahead of the primary, and each clamp, reset, clock and SRAM transition happens only once its predecessor in the up or down order is done. It also checks that bus protection brackets the sequence, that the off flag rises only after both status inputs read 0, that the error cycle leaves the outputs frozen, and that redundant requests never start a sequence. The bench scenarios cover what needs stimulus over time. These are timeouts caused by disagreeing status readbacks, stuck SRAM or bus acknowledges, and a status that stays on during power-down. They also include the timeout length, recovery after a clear, requests issued mid-sequence, ignored acknowledge bits, and the duration of the fixed-wait variant.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;
  localparam int unsigned CTRL_W    = 5;
  localparam int unsigned CB_RSTN   = 0;
  localparam int unsigned CB_ISO    = 1;
  localparam int unsigned CB_SW1    = 2;
  localparam int unsigned CB_SW2    = 3;
  localparam int unsigned CB_CLKDIS = 4;
  localparam logic [CTRL_W-1:0] CTRL_OFF = 5'b10010;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_UP_SW1, ST_UP_SW2, ST_UP_WPWR, ST_UP_CLK, ST_UP_ISO, ST_UP_RST,
    ST_UP_SRAM, ST_UP_WSRAM, ST_UP_BUS, ST_UP_WBUS,
    ST_DN_BUS, ST_DN_WBUS, ST_DN_SRAM, ST_DN_WSRAM, ST_DN_ISO, ST_DN_RST,
    ST_DN_CLK, ST_DN_SW1, ST_DN_SW2, ST_DN_WPWR
  } seq_st_e;
endpackage

// File: rtl/pd_poll_timer.sv
module pd_poll_timer #(
  parameter int unsigned TICK_CYC = 500,
  parameter int unsigned CNT_W    = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             tick_o,
  output logic             reach_o
);
  localparam int unsigned DIV_W = $clog2(TICK_CYC + 1);

  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q;

  assign tick_o  = (div_q == DIV_W'(TICK_CYC - 1));
  assign reach_o = tick_o && (cnt_q == limit_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (restart_i) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      div_q <= tick_o ? '0 : div_q + 1'b1;
      if (tick_o) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pd_cond_eval.sv
module pd_cond_eval #(
  parameter int unsigned         SRAM_W        = 4,
  parameter logic [SRAM_W-1:0]   SRAM_ACK_MASK = '1,
  parameter bit                  HAS_BUS_PROT  = 1'b1
) (
  input  logic              pwr_sta_i,
  input  logic              pwr_sta2_i,
  input  logic [SRAM_W-1:0] sram_ack_i,
  input  logic              bus_ack_i,
  output logic              pwr_on_o,
  output logic              pwr_off_o,
  output logic              ack_clr_o,
  output logic              ack_set_o,
  output logic              bus_ack_o
);
  // Both readbacks must agree; a split reading is a transition
  assign pwr_on_o  = pwr_sta_i & pwr_sta2_i;
  assign pwr_off_o = ~pwr_sta_i & ~pwr_sta2_i;

  generate
    if (SRAM_ACK_MASK == '0) begin : g_no_ack
      assign ack_clr_o = 1'b1;
      assign ack_set_o = 1'b1;
    end else begin : g_ack
      assign ack_clr_o = (sram_ack_i & SRAM_ACK_MASK) == '0;
      assign ack_set_o = (sram_ack_i & SRAM_ACK_MASK) == SRAM_ACK_MASK;
    end
    if (HAS_BUS_PROT) begin : g_bus
      assign bus_ack_o = bus_ack_i;
    end else begin : g_nobus
      assign bus_ack_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/pd_seq_fsm.sv
module pd_seq_fsm
  import pd_seq_pkg::*;
#(
  parameter int unsigned       SRAM_W           = 4,
  parameter logic [SRAM_W-1:0] SRAM_PDN_MASK    = '1,
  parameter bit                USE_FIXED_WAIT   = 1'b0,
  parameter bit                HAS_BUS_PROT     = 1'b1,
  parameter int unsigned       TIMEOUT_TICKS    = 100000,
  parameter int unsigned       FIXED_WAIT_TICKS = 1200,
  parameter int unsigned       CNT_W            = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_on_i,
  input  logic              err_clr_i,
  input  logic              tick_i,
  input  logic              reach_i,
  input  logic              pwr_on_i,
  input  logic              pwr_off_i,
  input  logic              ack_clr_i,
  input  logic              ack_set_i,
  input  logic              bus_ack_i,
  output logic              restart_o,
  output logic [CNT_W-1:0]  limit_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [SRAM_W-1:0] sram_pdn_o,
  output logic              bus_prot_o,
  output logic              busy_o,
  output logic              dom_on_o,
  output logic              dom_off_o,
  output logic              err_o
);
  seq_st_e st_q, st_d;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [SRAM_W-1:0] pdn_q, pdn_d;
  logic prot_q, prot_d, on_q, on_d, off_q, off_d, err_q, err_d;
  logic fail, fin_up;

  always_comb begin
    st_d   = st_q;
    ctrl_d = ctrl_q;
    pdn_d  = pdn_q;
    prot_d = prot_q;
    on_d   = on_q;
    off_d  = off_q;
    err_d  = err_q & ~err_clr_i;
    fail   = 1'b0;
    fin_up = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_valid_i) begin
        if (req_on_i && !on_q) begin
          st_d  = ST_UP_SW1;
          off_d = 1'b0;
        end else if (!req_on_i && !off_q) begin
          st_d = HAS_BUS_PROT ? ST_DN_BUS : ST_DN_SRAM;
          on_d = 1'b0;
        end
      end
      ST_UP_SW1:  begin ctrl_d[CB_SW1] = 1'b1; st_d = ST_UP_SW2; end
      ST_UP_SW2:  begin ctrl_d[CB_SW2] = 1'b1; st_d = ST_UP_WPWR; end
      ST_UP_WPWR: if (tick_i && pwr_on_i) st_d = ST_UP_CLK;
                  else if (reach_i) fail = 1'b1;
      ST_UP_CLK:  begin ctrl_d[CB_CLKDIS] = 1'b0; st_d = ST_UP_ISO; end
      ST_UP_ISO:  begin ctrl_d[CB_ISO] = 1'b0; st_d = ST_UP_RST; end
      ST_UP_RST:  begin ctrl_d[CB_RSTN] = 1'b1; st_d = ST_UP_SRAM; end
      ST_UP_SRAM: begin pdn_d = '0; st_d = ST_UP_WSRAM; end
      ST_UP_WSRAM: begin
        if (USE_FIXED_WAIT) begin
          if (reach_i) begin
            if (HAS_BUS_PROT) st_d = ST_UP_BUS; else fin_up = 1'b1;
          end
        end else if (tick_i && ack_clr_i) begin
          if (HAS_BUS_PROT) st_d = ST_UP_BUS; else fin_up = 1'b1;
        end else if (reach_i) fail = 1'b1;
      end
      ST_UP_BUS:  begin prot_d = 1'b0; st_d = ST_UP_WBUS; end
      ST_UP_WBUS: if (tick_i && !bus_ack_i) fin_up = 1'b1;
                  else if (reach_i) fail = 1'b1;
      ST_DN_BUS:  begin prot_d = 1'b1; st_d = ST_DN_WBUS; end
      ST_DN_WBUS: if (tick_i && bus_ack_i) st_d = ST_DN_SRAM;
                  else if (reach_i) fail = 1'b1;
      ST_DN_SRAM: begin pdn_d = SRAM_PDN_MASK; st_d = ST_DN_WSRAM; end
      ST_DN_WSRAM: if (tick_i && ack_set_i) st_d = ST_DN_ISO;
                   else if (reach_i) fail = 1'b1;
      ST_DN_ISO:  begin ctrl_d[CB_ISO] = 1'b1; st_d = ST_DN_RST; end
      ST_DN_RST:  begin ctrl_d[CB_RSTN] = 1'b0; st_d = ST_DN_CLK; end
      ST_DN_CLK:  begin ctrl_d[CB_CLKDIS] = 1'b1; st_d = ST_DN_SW1; end
      ST_DN_SW1:  begin ctrl_d[CB_SW1] = 1'b0; st_d = ST_DN_SW2; end
      ST_DN_SW2:  begin ctrl_d[CB_SW2] = 1'b0; st_d = ST_DN_WPWR; end
      ST_DN_WPWR: if (tick_i && pwr_off_i) begin
                    st_d  = ST_IDLE;
                    off_d = 1'b1;
                  end else if (reach_i) fail = 1'b1;
      default:    st_d = ST_IDLE;
    endcase
    if (fin_up) begin
      st_d = ST_IDLE;
      on_d = 1'b1;
    end
    if (fail) begin
      st_d  = ST_IDLE;
      err_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ctrl_q <= CTRL_OFF;
      pdn_q  <= SRAM_PDN_MASK;
      prot_q <= HAS_BUS_PROT;
      on_q   <= 1'b0;
      off_q  <= 1'b1;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      ctrl_q <= ctrl_d;
      pdn_q  <= pdn_d;
      prot_q <= prot_d;
      on_q   <= on_d;
      off_q  <= off_d;
      err_q  <= err_d;
    end
  end

  assign restart_o  = (st_d != st_q);
  assign limit_o    = (USE_FIXED_WAIT && st_q == ST_UP_WSRAM) ? CNT_W'(FIXED_WAIT_TICKS)
                                                               : CNT_W'(TIMEOUT_TICKS);
  assign ctrl_o     = ctrl_q;
  assign sram_pdn_o = pdn_q;
  assign bus_prot_o = prot_q;
  assign busy_o     = (st_q != ST_IDLE);
  assign dom_on_o   = on_q;
  assign dom_off_o  = off_q;
  assign err_o      = err_q;
endmodule

// File: rtl/pd_seq_top.sv
module pd_seq_top #(
  parameter int unsigned       TICK_CYC         = 500,
  parameter int unsigned       TIMEOUT_TICKS    = 100000,
  parameter int unsigned       FIXED_WAIT_TICKS = 1200,
  parameter int unsigned       SRAM_W           = 4,
  parameter logic [SRAM_W-1:0] SRAM_PDN_MASK    = '1,
  parameter logic [SRAM_W-1:0] SRAM_ACK_MASK    = '1,
  parameter bit                USE_FIXED_WAIT   = 1'b0,
  parameter bit                HAS_BUS_PROT     = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_on_i,
  input  logic              err_clr_i,
  input  logic              pwr_sta_i,
  input  logic              pwr_sta2_i,
  input  logic [SRAM_W-1:0] sram_ack_i,
  input  logic              bus_ack_i,
  output logic [4:0]        ctrl_o,
  output logic [SRAM_W-1:0] sram_pdn_o,
  output logic              bus_prot_o,
  output logic              busy_o,
  output logic              dom_on_o,
  output logic              dom_off_o,
  output logic              err_o
);
  localparam int unsigned MAX_TICKS = (TIMEOUT_TICKS > FIXED_WAIT_TICKS) ? TIMEOUT_TICKS
                                                                         : FIXED_WAIT_TICKS;
  localparam int unsigned CNT_W = $clog2(MAX_TICKS + 1);

  logic tick, reach, restart;
  logic [CNT_W-1:0] limit;
  logic pwr_on, pwr_off, ack_clr, ack_set, bus_ack;

  pd_poll_timer #(.TICK_CYC(TICK_CYC), .CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .restart_i(restart), .limit_i(limit),
    .tick_o(tick), .reach_o(reach)
  );

  pd_cond_eval #(.SRAM_W(SRAM_W), .SRAM_ACK_MASK(SRAM_ACK_MASK),
                 .HAS_BUS_PROT(HAS_BUS_PROT)) u_cond (
    .pwr_sta_i, .pwr_sta2_i, .sram_ack_i, .bus_ack_i,
    .pwr_on_o(pwr_on), .pwr_off_o(pwr_off), .ack_clr_o(ack_clr),
    .ack_set_o(ack_set), .bus_ack_o(bus_ack)
  );

  pd_seq_fsm #(
    .SRAM_W(SRAM_W), .SRAM_PDN_MASK(SRAM_PDN_MASK), .USE_FIXED_WAIT(USE_FIXED_WAIT),
    .HAS_BUS_PROT(HAS_BUS_PROT), .TIMEOUT_TICKS(TIMEOUT_TICKS),
    .FIXED_WAIT_TICKS(FIXED_WAIT_TICKS), .CNT_W(CNT_W)
  ) u_fsm (
    .clk_i, .rst_ni, .req_valid_i, .req_on_i, .err_clr_i,
    .tick_i(tick), .reach_i(reach), .pwr_on_i(pwr_on), .pwr_off_i(pwr_off),
    .ack_clr_i(ack_clr), .ack_set_i(ack_set), .bus_ack_i(bus_ack),
    .restart_o(restart), .limit_o(limit),
    .ctrl_o, .sram_pdn_o, .bus_prot_o, .busy_o, .dom_on_o, .dom_off_o, .err_o
  );
endmodule

// File: rtl/pd_seq_chk.sv
module pd_seq_chk #(
  parameter int unsigned       SRAM_W        = 4,
  parameter logic [SRAM_W-1:0] SRAM_PDN_MASK = '1,
  parameter bit                HAS_BUS_PROT  = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_on_i,
  input logic              err_clr_i,
  input logic              pwr_sta_i,
  input logic              pwr_sta2_i,
  input logic [4:0]        ctrl_o,
  input logic [SRAM_W-1:0] sram_pdn_o,
  input logic              bus_prot_o,
  input logic              busy_o,
  input logic              dom_on_o,
  input logic              dom_off_o,
  input logic              err_o
);
  a_r3_sw2_after_sw1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_o[3]) |-> ctrl_o[2] && $past(ctrl_o[2]));
  a_r4_clk_needs_switches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_o[4]) |-> ctrl_o[2] && ctrl_o[3]);
  a_r5_iso_after_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_o[1]) |-> !ctrl_o[4]);
  a_r5_rst_after_iso: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_o[0]) |-> !ctrl_o[1]);
  a_r5_sram_after_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sram_pdn_o) != '0 && sram_pdn_o == '0) |-> ctrl_o[0]);
  a_r7_prot_release_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (HAS_BUS_PROT && $fell(bus_prot_o)) |-> sram_pdn_o == '0 && ctrl_o[0]);
  a_r7_prot_before_sram: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (HAS_BUS_PROT && $past(sram_pdn_o) == '0 && sram_pdn_o != '0) |-> bus_prot_o);
  a_r8_iso_after_sram: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_o[1]) |-> sram_pdn_o == SRAM_PDN_MASK);
  a_r8_rst_after_iso: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_o[0]) |-> ctrl_o[1]);
  a_r8_clk_after_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_o[4]) |-> !ctrl_o[0]);
  a_r8_sw1_after_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_o[2]) |-> ctrl_o[4]);
  a_r8_sw2_after_sw1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_o[3]) |-> !ctrl_o[2]);
  a_r9_off_needs_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dom_off_o) |-> $past(!pwr_sta_i && !pwr_sta2_i));
  a_r10_err_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err_o) |-> $past(err_clr_i));
  a_r10_err_no_undo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $stable(ctrl_o) && $stable(sram_pdn_o) && $stable(bus_prot_o) && !busy_o);
  a_r12_redundant_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_valid_i && ((req_on_i && dom_on_o) || (!req_on_i && dom_off_o)))
      |=> !busy_o && $stable(ctrl_o));
endmodule

bind pd_seq_top pd_seq_chk #(
  .SRAM_W(SRAM_W), .SRAM_PDN_MASK(SRAM_PDN_MASK), .HAS_BUS_PROT(HAS_BUS_PROT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_on_i(req_on_i),
  .err_clr_i(err_clr_i), .pwr_sta_i(pwr_sta_i), .pwr_sta2_i(pwr_sta2_i),
  .ctrl_o(ctrl_o), .sram_pdn_o(sram_pdn_o), .bus_prot_o(bus_prot_o), .busy_o(busy_o),
  .dom_on_o(dom_on_o), .dom_off_o(dom_off_o), .err_o(err_o)
);

// File: tb/pd_seq_top_tb_top.sv
module pd_seq_top_tb_top;
  localparam int TICK = 4;
  localparam int TMO  = 16;
  localparam int FW   = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req_valid = 1'b0, req_on = 1'b0, err_clr = 1'b0;
  logic kill_sta2 = 1'b0, force_on = 1'b0, block_ack = 1'b0, bus_stuck = 1'b0;
  logic [3:0] ack_or = 4'b1000;
  logic sta_m = 1'b0, sta2_m = 1'b0, bus_ack_m = 1'b0;
  logic [3:0] ack_m = 4'b0000;
  logic [4:0] ctrl;
  logic [3:0] pdn;
  logic prot, busy, on, off, err;

  logic fw_req_valid = 1'b0, fw_req_on = 1'b0;
  logic fw_sta = 1'b0, fw_sta2 = 1'b0;
  logic [4:0] fw_ctrl;
  logic [3:0] fw_pdn;
  logic fw_prot, fw_busy, fw_on, fw_off, fw_err;

  pd_seq_top #(
    .TICK_CYC(TICK), .TIMEOUT_TICKS(TMO), .FIXED_WAIT_TICKS(FW), .SRAM_W(4),
    .SRAM_PDN_MASK(4'b0111), .SRAM_ACK_MASK(4'b0011), .USE_FIXED_WAIT(1'b0),
    .HAS_BUS_PROT(1'b1)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_on_i(req_on),
    .err_clr_i(err_clr), .pwr_sta_i(sta_m), .pwr_sta2_i(sta2_m), .sram_ack_i(ack_m),
    .bus_ack_i(bus_ack_m), .ctrl_o(ctrl), .sram_pdn_o(pdn), .bus_prot_o(prot),
    .busy_o(busy), .dom_on_o(on), .dom_off_o(off), .err_o(err)
  );

  pd_seq_top #(
    .TICK_CYC(TICK), .TIMEOUT_TICKS(TMO), .FIXED_WAIT_TICKS(FW), .SRAM_W(4),
    .SRAM_PDN_MASK(4'b1111), .SRAM_ACK_MASK(4'b1111), .USE_FIXED_WAIT(1'b1),
    .HAS_BUS_PROT(1'b0)
  ) dut_fw_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(fw_req_valid), .req_on_i(fw_req_on),
    .err_clr_i(1'b0), .pwr_sta_i(fw_sta), .pwr_sta2_i(fw_sta2), .sram_ack_i(4'b1111),
    .bus_ack_i(1'b0), .ctrl_o(fw_ctrl), .sram_pdn_o(fw_pdn), .bus_prot_o(fw_prot),
    .busy_o(fw_busy), .dom_on_o(fw_on), .dom_off_o(fw_off), .err_o(fw_err)
  );

  // Island models: readbacks follow the controls one cycle later
  always @(posedge clk) begin
    sta_m     <= (ctrl[2] | force_on);
    sta2_m    <= (ctrl[3] | force_on) & ~kill_sta2;
    ack_m     <= block_ack ? 4'b0000 : (pdn | ack_or);
    bus_ack_m <= prot | bus_stuck;
    fw_sta    <= fw_ctrl[2];
    fw_sta2   <= fw_ctrl[3];
  end

  typedef struct {
    string      tag;
    logic [4:0] ctrl;
    logic [3:0] pdn;
    logic       prot, on, off, err;
  } exp_t;

  exp_t exp_q[$];
  event chk_ev;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // Monitor: pops expected items and compares against the outputs
  initial forever begin
    @(chk_ev);
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_cmp++;
      if (ctrl !== e.ctrl || pdn !== e.pdn || prot !== e.prot || on !== e.on ||
          off !== e.off || err !== e.err || busy !== 1'b0) begin
        n_bad++;
        $display("FAIL %s: got ctrl=%b pdn=%b prot=%b on=%b off=%b err=%b busy=%b; exp ctrl=%b pdn=%b prot=%b on=%b off=%b err=%b busy=0",
                 e.tag, ctrl, pdn, prot, on, off, err, busy,
                 e.ctrl, e.pdn, e.prot, e.on, e.off, e.err);
      end
    end
  end

  task automatic expect_state(input string tag, input logic [4:0] c, input logic [3:0] p,
                              input logic pr, input logic o, input logic f, input logic er);
    exp_t e;
    e.tag = tag; e.ctrl = c; e.pdn = p; e.prot = pr; e.on = o; e.off = f; e.err = er;
    exp_q.push_back(e);
    -> chk_ev;
    #1;
  endtask

  task automatic chk_val(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d exp %0d", tag, act, exp);
    end
  endtask

  task automatic chk_min(input string tag, input int act, input int lim);
    n_cmp++;
    if (act < lim) begin
      n_bad++;
      $display("FAIL %s: got %0d exp >= %0d", tag, act, lim);
    end
  endtask

  task automatic run_req(input logic dir, output int cyc, output bit saw_busy);
    @(negedge clk);
    req_valid = 1'b1; req_on = dir;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    saw_busy = busy;
    while (busy) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic clear_err();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got running exp finished");
    summary();
    $finish;
  end

  initial begin
    int  cyc;
    bit  saw;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_state("R1 reset state", 5'b10010, 4'b0111, 1'b1, 1'b0, 1'b1, 1'b0);
    chk_val("R1 fixed-wait variant reset ctrl", int'(fw_ctrl), int'(5'b10010));
    chk_val("R1 no-protection variant holds request low", int'(fw_prot), 0);

    // Full power-up; ack bit 3 stuck high but not selected
    run_req(1'b1, cyc, saw);
    expect_state("R2 R3 R5 R6 R7 power-up", 5'b01101, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0);

    run_req(1'b1, cyc, saw);
    chk_val("R12 redundant on stays idle", int'(saw), 0);
    expect_state("R12 redundant on leaves outputs", 5'b01101, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0);

    // Power-down with a conflicting request injected mid-sequence
    @(negedge clk); req_valid = 1'b1; req_on = 1'b0;
    @(negedge clk); req_on = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    while (busy) @(negedge clk);
    expect_state("R8 R11 power-down ignoring mid request", 5'b10010, 4'b0111, 1'b1, 1'b0, 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    chk_val("R11 no second sequence", int'(busy), 0);

    run_req(1'b0, cyc, saw);
    chk_val("R12 redundant off stays idle", int'(saw), 0);

    // Secondary status never reports on: split reading times out
    kill_sta2 = 1'b1;
    run_req(1'b1, cyc, saw);
    expect_state("R4 R10 split status timeout", 5'b11110, 4'b0111, 1'b1, 1'b0, 1'b0, 1'b1);
    chk_min("R10 timeout length", cyc, TMO * TICK);
    clear_err();
    expect_state("R10 error cleared", 5'b11110, 4'b0111, 1'b1, 1'b0, 1'b0, 1'b0);
    kill_sta2 = 1'b0;
    run_req(1'b1, cyc, saw);
    expect_state("R4 recovery power-up", 5'b01101, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0);

    // SRAM never acknowledges power-down: stop before isolation
    block_ack = 1'b1;
    run_req(1'b0, cyc, saw);
    expect_state("R8 SRAM ack timeout", 5'b01101, 4'b0111, 1'b1, 1'b0, 1'b0, 1'b1);
    clear_err();
    block_ack = 1'b0;

    // Status stays on after switches dropped
    force_on = 1'b1;
    run_req(1'b0, cyc, saw);
    expect_state("R9 status stuck on", 5'b10010, 4'b0111, 1'b1, 1'b0, 1'b0, 1'b1);
    clear_err();
    force_on = 1'b0;
    run_req(1'b0, cyc, saw);
    expect_state("R9 power-down completes", 5'b10010, 4'b0111, 1'b1, 1'b0, 1'b1, 1'b0);

    // Bus fabric keeps acknowledging protection
    bus_stuck = 1'b1;
    run_req(1'b1, cyc, saw);
    expect_state("R7 bus release timeout", 5'b01101, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b1);
    clear_err();
    bus_stuck = 1'b0;
    run_req(1'b1, cyc, saw);
    expect_state("R7 recovery", 5'b01101, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0);

    // Fixed-wait variant: ack held high throughout, must still finish
    @(negedge clk); fw_req_valid = 1'b1; fw_req_on = 1'b1;
    @(negedge clk); fw_req_valid = 1'b0;
    cyc = 1;
    while (fw_busy) begin
      @(negedge clk);
      cyc++;
    end
    chk_min("R6 fixed wait duration", cyc, FW * TICK);
    chk_val("R6 fixed wait on flag", int'(fw_on), 1);
    chk_val("R6 fixed wait no error", int'(fw_err), 0);
    chk_val("R6 fixed wait ctrl", int'(fw_ctrl), int'(5'b01101));
    chk_val("R6 fixed wait SRAM cleared", int'(fw_pdn), 0);

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule